// File: doc/BRIEF.md
# Multiprocessor Address Filter for a 9-bit Serial Receiver

This block sits after a 9-bit serial receiver on a shared multidrop line. It decides whether a received address frame is meant for this node, and with that whether the receive-complete flag may be set. Two registers are written over a small write-only register bus. The node-address register gives the required bit values. The select-mask register marks which of those bits take part in the comparison.

Each incoming byte is compared against two patterns. The first is the *given* pattern: bits where the mask holds 1 must equal the node address, and all other bits are free. The second is the *broadcast* pattern, formed as node address OR mask. Every 1 in that pattern must be 1 in the byte, and every 0 is free. A byte that fits either pattern is a hit.

When multiprocessor filtering is enabled, only frames whose ninth bit is 1 (address frames) and that hit may set the flag. When filtering is disabled, every completed frame sets the flag. After reset both registers are zero, so every byte hits and the block behaves as a plain receiver.

Top module: `uart_addr_filter`

## Requirements
- R1: Reset clears the node-address and select-mask registers to 0, so that after reset every received byte gives `addr_hit` = 1.
- R2: The given match is true when every bit position with mask = 1 has byte bit equal to address bit. For example, address 0xC0 with mask 0xF9 accepts 0xC6, address 0xE0 with mask 0xFA accepts 0xE5, and address 0xE0 with mask 0xFC accepts 0xE3.
- R3: The broadcast match is true when every bit that is 1 in (address OR mask) is also 1 in the byte. For example, address 0xE0 with mask 0xFC accepts 0xFC and 0xFF.
- R4: `addr_hit` is 1 exactly when the given match or the broadcast match is true. For example, address 0xE0 with mask 0xFC gives 0 for byte 0xE4.
- R5: With `mp_en` = 1, a completed frame whose ninth bit is 0 never produces `rx_flag_set`.
- R6: With `mp_en` = 1, a completed frame whose ninth bit is 1 produces `rx_flag_set` exactly when `addr_hit` is 1.
- R7: With `mp_en` = 0, every cycle with `rx_done` = 1 produces `rx_flag_set`, whatever the byte, the ninth bit and the registers are.
- R8: `rx_flag_set` is combinational and is 1 only in a cycle where `rx_done` is 1. A one-cycle strobe therefore gives a one-cycle pulse.
- R9: A cycle with `reg_wr` = 1 loads `reg_wdata` into the node-address register when `reg_sel` = 0, or into the select-mask register when `reg_sel` = 1. The new value takes effect from the next cycle, so a frame that completes in the write cycle is judged with the old values.
- R10: `addr_hit` follows `rx_byte` in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 node address, 1 select mask |
| reg_wdata | input | 8 | Register write data |
| rx_byte | input | 8 | Received data byte |
| rx_bit9 | input | 1 | Received ninth bit (1 = address frame) |
| rx_done | input | 1 | Frame-complete strobe from the receiver |
| mp_en | input | 1 | Multiprocessor filtering enable |
| addr_hit | output | 1 | Byte fits the given or the broadcast pattern |
| rx_flag_set | output | 1 | Gated set pulse for the receive-complete flag |

## Verification
A register write and a frame completion can land in the same cycle. The comparison must then use the register contents from before the write. The bench provokes this by rewriting the node address in the very cycle an address frame completes, choosing a byte that hits under the old address and misses under the new one. It expects the flag pulse in that cycle, and in the following cycle it checks that the same byte now misses while a byte that fits the new address hits.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;

    parameter int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        SEL_NODE = 1'b0,
        SEL_MASK = 1'b1
    } reg_sel_e;

    typedef struct packed {
        byte_t node;
        byte_t mask;
    } filt_cfg_t;

    typedef struct packed {
        logic given;
        logic bcast;
    } hit_t;

    function automatic byte_t bcast_pattern(filt_cfg_t c);
        return c.node | c.mask;
    endfunction

endpackage

// File: rtl/filt_regs.sv
module filt_regs
    import addr_filt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  reg_sel_e  sel,
    input  byte_t     wdata,
    output filt_cfg_t cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr) begin
            case (sel)
                SEL_NODE: cfg.node <= wdata;
                SEL_MASK: cfg.mask <= wdata;
                default:  cfg      <= cfg;
            endcase
        end
    end

endmodule

// File: rtl/filt_match.sv
module filt_match
    import addr_filt_pkg::*;
(
    input  filt_cfg_t cfg,
    input  byte_t     rx_byte,
    output hit_t      hit
);

    byte_t bpat;
    byte_t given_miss;
    byte_t bcast_miss;

    assign bpat = bcast_pattern(cfg);

    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        assign given_miss[i] = cfg.mask[i] & (rx_byte[i] ^ cfg.node[i]);
        assign bcast_miss[i] = bpat[i] & ~rx_byte[i];
    end

    always_comb begin
        hit.given = ~|given_miss;
        hit.bcast = ~|bcast_miss;
    end

endmodule

// File: rtl/filt_gate.sv
module filt_gate
    import addr_filt_pkg::*;
(
    input  hit_t hit,
    input  logic bit9,
    input  logic done,
    input  logic mp_en,
    output logic any_hit,
    output logic flag_set
);

    always_comb begin
        any_hit  = hit.given | hit.bcast;
        flag_set = done & (~mp_en | (bit9 & any_hit));
    end

endmodule

// File: rtl/uart_addr_filter.sv
module uart_addr_filter
    import addr_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_bit9,
    input  logic              rx_done,
    input  logic              mp_en,
    output logic              addr_hit,
    output logic              rx_flag_set
);

    filt_cfg_t cfg;
    hit_t      hit;

    filt_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .sel   (reg_sel_e'(reg_sel)),
        .wdata (reg_wdata),
        .cfg   (cfg)
    );

    filt_match u_match (
        .cfg     (cfg),
        .rx_byte (rx_byte),
        .hit     (hit)
    );

    filt_gate u_gate (
        .hit      (hit),
        .bit9     (rx_bit9),
        .done     (rx_done),
        .mp_en    (mp_en),
        .any_hit  (addr_hit),
        .flag_set (rx_flag_set)
    );

endmodule

// File: rtl/filt_chk.sv
module filt_chk (
    input logic clk,
    input logic rst,
    input logic rx_bit9,
    input logic rx_done,
    input logic mp_en,
    input logic addr_hit,
    input logic rx_flag_set
);

    AST_RESET_OPEN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> addr_hit); // R1

    AST_DATA_FRAME_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (mp_en && !rx_bit9) |-> !rx_flag_set); // R5

    AST_MISS_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (mp_en && !addr_hit) |-> !rx_flag_set); // R6

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (!mp_en && rx_done) |-> rx_flag_set); // R7

    AST_PULSE_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
        rx_flag_set |-> rx_done); // R8

endmodule

bind uart_addr_filter filt_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_bit9     (rx_bit9),
    .rx_done     (rx_done),
    .mp_en       (mp_en),
    .addr_hit    (addr_hit),
    .rx_flag_set (rx_flag_set)
);

// File: tb/sim_uart_addr_filter.sv
`timescale 1ns/1ps
module sim_uart_addr_filter;

    logic       clk = 1'b0;
    logic       rst;
    logic       reg_wr;
    logic       reg_sel;
    logic [7:0] reg_wdata;
    logic [7:0] rx_byte;
    logic       rx_bit9;
    logic       rx_done;
    logic       mp_en;
    logic       addr_hit;
    logic       rx_flag_set;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    uart_addr_filter u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .rx_byte(rx_byte), .rx_bit9(rx_bit9),
        .rx_done(rx_done), .mp_en(mp_en), .addr_hit(addr_hit),
        .rx_flag_set(rx_flag_set)
    );

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b (byte=%02h)", req, act, exp, rx_byte);
        end
    endtask

    function automatic logic exp_hit(input logic [7:0] a, input logic [7:0] m, input logic [7:0] b);
        logic [7:0] bc;
        bc = a | m;
        return (((b ^ a) & m) == 8'h00) || ((b & bc) == bc);
    endfunction

    task automatic write_reg(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Sweep all bytes, ninth-bit and enable values for one configuration
    task automatic sweep(input logic [7:0] a, input logic [7:0] m);
        for (int b = 0; b < 256; b++) begin
            for (int k = 0; k < 4; k++) begin
                logic eh;
                @(negedge clk);
                rx_byte = 8'(b); rx_bit9 = k[0]; mp_en = k[1]; rx_done = 1'b1;
                #1;
                eh = exp_hit(a, m, 8'(b));
                check(addr_hit, eh, "R4 R10 hit");
                if (!k[1])      check(rx_flag_set, 1'b1, "R7 pass-through");
                else if (!k[0]) check(rx_flag_set, 1'b0, "R5 data frame");
                else            check(rx_flag_set, eh,   "R6 address frame");
            end
        end
        @(negedge clk);
        rx_done = 1'b0; mp_en = 1'b0;
        #1;
        check(rx_flag_set, 1'b0, "R8 no strobe");
    endtask

    task automatic config_sweep(input logic [7:0] a, input logic [7:0] m);
        write_reg(1'b0, a);
        write_reg(1'b1, m);
        sweep(a, m);
    endtask

    task automatic point(input logic [7:0] b, input logic exp, input string req);
        @(negedge clk);
        rx_byte = b;
        #1;
        check(addr_hit, exp, req);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = 8'h00;
        rx_byte = 8'h00; rx_bit9 = 1'b0; rx_done = 1'b0; mp_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: registers cleared, every byte hits
        for (int b = 0; b < 256; b++) begin
            @(negedge clk);
            rx_byte = 8'(b);
            #1;
            check(addr_hit, 1'b1, "R1 reset open");
        end
        sweep(8'h00, 8'h00);

        // R2 given-pattern examples
        write_reg(1'b0, 8'hC0); write_reg(1'b1, 8'hF9);
        point(8'hC6, 1'b1, "R2 C0/F9 C6");
        write_reg(1'b0, 8'hE0); write_reg(1'b1, 8'hFA);
        point(8'hE5, 1'b1, "R2 E0/FA E5");
        write_reg(1'b1, 8'hFC);
        point(8'hE3, 1'b1, "R2 E0/FC E3");
        point(8'hE4, 1'b0, "R4 E0/FC E4");
        // R3 broadcast pattern FC
        point(8'hFC, 1'b1, "R3 bcast FC");
        point(8'hFF, 1'b1, "R3 bcast FF");
        point(8'hF8, 1'b0, "R3 bcast F8");

        // R9: write and frame completion in the same cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h10;
        rx_byte = 8'hE3; rx_bit9 = 1'b1; mp_en = 1'b1; rx_done = 1'b1;
        #1;
        check(rx_flag_set, 1'b1, "R9 old values in write cycle");
        @(negedge clk);
        reg_wr = 1'b0; rx_done = 1'b0;
        #1;
        check(addr_hit, 1'b0, "R9 new address E3");
        check(rx_flag_set, 1'b0, "R8 no strobe");
        point(8'h13, 1'b1, "R9 new address 13");
        // R9: mask write targets mask only
        write_reg(1'b1, 8'h00);
        point(8'h5A, 1'b1, "R9 mask cleared");
        mp_en = 1'b0;

        // Full sweeps over several configurations
        config_sweep(8'hC0, 8'hF9);
        config_sweep(8'hE0, 8'hFA);
        config_sweep(8'hE0, 8'hFC);
        config_sweep(8'hA5, 8'h0F);
        config_sweep(8'h3C, 8'hF0);
        config_sweep(8'hFF, 8'hFF);
        config_sweep(8'h00, 8'hFF);
        config_sweep(8'h81, 8'h00);

        // R1 again: reset after configuration reopens the filter
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        point(8'h00, 1'b1, "R1 reset after config");
        point(8'h7E, 1'b1, "R1 reset after config");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule